// File: doc/BRIEF.md
# Shadow-Buffered Coefficient Batch Loader

This block receives coefficient updates from a host over a clocked serial link framed by an active-low select. Each frame carries a device address byte, a command byte, a 16-bit coefficient RAM start address and one to thirty-two 16-bit data words. The block does not send these words to the live coefficient RAM. It places them in a 32-entry shadow buffer.

Once the frame has closed, the block waits for the next sample-rate strobe. It then copies the whole buffered set into the coefficient RAM on consecutive system clocks, all within that one sample period. A running filter therefore never computes with a mixture of old and new coefficients. While a set is waiting for the strobe or being copied, the block refuses any further addressed frame and reports it as an error.

The serial inputs are asynchronous to the system clock and are synchronised inside the block. The sample period must span more than 32 system clocks.

Top module: `coef_batch_loader`

## Requirements
- R1: A frame is the bits sampled on rising edges of `ser_clk` while `ser_csn` is low, MSB first: device address (8 bits), command (8 bits), start address (16 bits), then data words of 16 bits each. The frame ends when `ser_csn` rises.
- R2: No coefficient RAM write (`ram_we`) takes place while a frame is being received or while a completed set waits for its strobe.
- R3: On the first `fs_strobe` after a frame that completes at least one word, `ram_we` and `busy` go high in the cycle after the strobe and stay high for exactly n cycles. Word k goes to address (start + k) modulo 65536, in order k = 0..n-1.
- R4: At most 32 words are buffered. Any word after the 32nd is dropped, and the commit then writes exactly 32 words.
- R5: A frame whose device address differs from `DEV_ID` (default 0x5A) is ignored. It loads nothing, leaves no commit pending and raises no error.
- R6: A frame with the matching device address but a command other than `LOAD_OP` (default 0xA7) loads nothing and leaves no commit pending.
- R7: Trailing bits that do not form a full 16-bit word are discarded. A frame with no complete data word leaves no commit pending.
- R8: A frame carrying the matching device address that arrives while a commit is pending or in progress produces a one-cycle `cmd_error` pulse and is ignored. The pending set is committed unchanged.
- R9: After reset, `busy`, `ram_we` and `cmd_error` are low and no commit is pending.
- R10: An `fs_strobe` with no pending set writes nothing. A set is committed only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Host serial clock; data is sampled on its rising edge |
| ser_csn | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data, MSB first |
| fs_strobe | input | 1 | One-cycle sample-period marker |
| ram_we | output | 1 | Coefficient RAM write enable |
| ram_addr | output | 16 | Coefficient RAM write address |
| ram_wdata | output | 16 | Coefficient RAM write data |
| busy | output | 1 | High during the cycles in which the commit writes |
| cmd_error | output | 1 | One-cycle pulse when an addressed frame arrives while locked |

## Verification
The bench sweeps the word count from 1 to 33. Each count uses different start addresses, one of them wrapping past 0xFFFF, and data that depends on both the frame and the word index. This separates an off-by-one in the word count, a missing cap and wrong address arithmetic from errors in the buffer indexing. Further frames carry a wrong device address, a wrong command, trailing partial bits or no complete word. These show which ones leave something pending. A second addressed frame sent while a set is pending shows that the error is raised and that the first set is committed unaltered. A spare strobe after each commit shows that nothing is written twice.

// File: rtl/coef_pkg.sv
package coef_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_SKIP = 2'd1,
    RX_BASE = 2'd2,
    RX_DATA = 2'd3
  } rx_phase_t;

  // coefficient RAM address for word k of a batch, wrapping at 2^16
  function automatic logic [15:0] batch_addr(input logic [15:0] base, input logic [15:0] k);
    return base + k;
  endfunction

  // true when the bit that is arriving closes a data word
  function automatic logic closes_word(input int unsigned bits_before, input int unsigned dw);
    int unsigned total;
    total = bits_before + 1;
    return (total > 2 * dw) && ((total % dw) == 0);
  endfunction

endpackage

// File: rtl/coef_serial_rx.sv
module coef_serial_rx #(
  parameter int DW   = 16,
  parameter int MAXW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_csn,
  input  logic          ser_din,
  output logic          hdr_evt,
  output logic          base_evt,
  output logic          word_evt,
  output logic          frame_end,
  output logic [DW-1:0] rx_word
);
  import coef_pkg::*;

  localparam int CW = $clog2((MAXW + 4) * DW);

  logic [2:0]    sclk_q;
  logic [2:0]    csn_q;
  logic [1:0]    din_q;
  logic [DW-1:0] shreg;
  logic [CW-1:0] bit_cnt;
  logic          cs_active;
  logic          bit_rise;
  logic          in_bit;

  assign cs_active = ~csn_q[1];
  assign in_bit    = din_q[1];
  assign bit_rise  = sclk_q[1] & ~sclk_q[2] & cs_active;
  assign frame_end = csn_q[1] & ~csn_q[2];
  assign rx_word   = {shreg[DW-2:0], in_bit};

  assign hdr_evt  = bit_rise && (int'(bit_cnt) == DW - 1);
  assign base_evt = bit_rise && (int'(bit_cnt) == 2 * DW - 1);
  assign word_evt = bit_rise && closes_word(int'(bit_cnt), DW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= '0;
      csn_q   <= '1;
      din_q   <= '0;
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], ser_clk};
      csn_q  <= {csn_q[1:0], ser_csn};
      din_q  <= {din_q[0], ser_din};
      if (!cs_active) begin
        bit_cnt <= '0;
      end else if (bit_rise) begin
        shreg <= rx_word;
        if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assert_single_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_evt, base_evt, word_evt, frame_end}));

  assert_count_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (bit_cnt == '0));

endmodule

// File: rtl/coef_shadow_buf.sv
module coef_shadow_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] entry [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            entry[g] <= '0;
      else if (we && (int'(waddr) == g))     entry[g] <= wdata;
    end
  end

  assign rdata = entry[raddr];

  assert_write_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/coef_commit_ctrl.sv
module coef_commit_ctrl #(
  parameter int          DEPTH    = 32,
  parameter int          DW       = 16,
  parameter int          AW       = 16,
  parameter logic [7:0]  DEV_ID   = 8'h5A,
  parameter logic [7:0]  LOAD_OP  = 8'hA7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hdr_evt,
  input  logic                     base_evt,
  input  logic                     word_evt,
  input  logic                     frame_end,
  input  logic [DW-1:0]            rx_word,
  input  logic                     fs_strobe,
  output logic                     buf_we,
  output logic [$clog2(DEPTH)-1:0] buf_waddr,
  output logic [DW-1:0]            buf_wdata,
  output logic [$clog2(DEPTH)-1:0] buf_raddr,
  output logic                     ram_we,
  output logic [AW-1:0]            ram_addr,
  output logic                     busy,
  output logic                     cmd_error
);
  import coef_pkg::*;

  localparam int IW = $clog2(DEPTH);
  localparam int NW = IW + 1;

  rx_phase_t     phase;
  logic [AW-1:0] base;
  logic [NW-1:0] wcnt;
  logic [NW-1:0] len;
  logic [NW-1:0] idx;
  logic          pending;
  logic          locked;
  logic          dev_match;
  logic          op_match;
  logic          commit_go;
  logic          commit_last;

  assign locked      = pending | busy;
  assign dev_match   = (rx_word[15:8] == DEV_ID);
  assign op_match    = (rx_word[7:0] == LOAD_OP);
  assign commit_go   = fs_strobe && pending && !busy;
  assign commit_last = busy && (idx == len - 1'b1);

  assign buf_we    = word_evt && (phase == RX_DATA) && (int'(wcnt) < DEPTH);
  assign buf_waddr = wcnt[IW-1:0];
  assign buf_wdata = rx_word;
  assign buf_raddr = idx[IW-1:0];
  assign ram_we    = busy;
  assign ram_addr  = batch_addr(base, 16'(idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= RX_IDLE;
      base      <= '0;
      wcnt      <= '0;
      len       <= '0;
      pending   <= 1'b0;
      cmd_error <= 1'b0;
    end else begin
      cmd_error <= 1'b0;
      if (hdr_evt) begin
        if (dev_match && locked) begin
          cmd_error <= 1'b1;
          phase     <= RX_SKIP;
        end else if (dev_match && op_match) begin
          phase <= RX_BASE;
          wcnt  <= '0;
        end else begin
          phase <= RX_SKIP;
        end
      end else if (base_evt && phase == RX_BASE) begin
        base  <= rx_word;
        phase <= RX_DATA;
      end else if (buf_we) begin
        wcnt <= wcnt + 1'b1;
      end else if (frame_end) begin
        phase <= RX_IDLE;
        if (phase == RX_DATA && wcnt != '0) begin
          pending <= 1'b1;
          len     <= wcnt;
        end
      end
      if (commit_go) pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (commit_go) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (commit_last) busy <= 1'b0;
    end
  end

  // window counter for the commit length check
  logic [NW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  assert_commit_within_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(run_len) < DEPTH));

  assert_start_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fs_strobe));

  assert_addr_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (ram_addr == $past(ram_addr) + 1'b1));

  assert_no_load_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !busy);

  assert_error_is_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_error |=> !cmd_error);

endmodule

// File: rtl/coef_batch_loader.sv
module coef_batch_loader #(
  parameter int         DEPTH   = 32,
  parameter int         DW      = 16,
  parameter int         AW      = 16,
  parameter logic [7:0] DEV_ID  = 8'h5A,
  parameter logic [7:0] LOAD_OP = 8'hA7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_csn,
  input  logic          ser_din,
  input  logic          fs_strobe,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          busy,
  output logic          cmd_error
);
  localparam int IW = $clog2(DEPTH);

  logic          hdr_evt;
  logic          base_evt;
  logic          word_evt;
  logic          frame_end;
  logic [DW-1:0] rx_word;
  logic          buf_we;
  logic [IW-1:0] buf_waddr;
  logic [DW-1:0] buf_wdata;
  logic [IW-1:0] buf_raddr;

  coef_serial_rx #(.DW(DW), .MAXW(DEPTH)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_csn  (ser_csn),
    .ser_din  (ser_din),
    .hdr_evt  (hdr_evt),
    .base_evt (base_evt),
    .word_evt (word_evt),
    .frame_end(frame_end),
    .rx_word  (rx_word)
  );

  coef_commit_ctrl #(
    .DEPTH(DEPTH), .DW(DW), .AW(AW), .DEV_ID(DEV_ID), .LOAD_OP(LOAD_OP)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdr_evt  (hdr_evt),
    .base_evt (base_evt),
    .word_evt (word_evt),
    .frame_end(frame_end),
    .rx_word  (rx_word),
    .fs_strobe(fs_strobe),
    .buf_we   (buf_we),
    .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .busy     (busy),
    .cmd_error(cmd_error)
  );

  coef_shadow_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (buf_we),
    .waddr(buf_waddr),
    .wdata(buf_wdata),
    .raddr(buf_raddr),
    .rdata(ram_wdata)
  );

  assert_no_write_during_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_csn && !busy) |=> !ram_we || $past(fs_strobe));

endmodule

// File: tb/coef_batch_loader_test.sv
module coef_batch_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_csn = 1'b1;
  logic        ser_din = 1'b0;
  logic        fs_strobe = 1'b0;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [15:0] ram_wdata;
  logic        busy;
  logic        cmd_error;

  localparam logic [7:0] DEV = 8'h5A;
  localparam logic [7:0] OP  = 8'hA7;

  always #4 clk = ~clk;

  coef_batch_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_csn(ser_csn), .ser_din(ser_din),
    .fs_strobe(fs_strobe), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .busy(busy), .cmd_error(cmd_error)
  );

  int checks = 0;
  int fails  = 0;
  int cap_n  = 0;
  int busy_n = 0;
  int err_n  = 0;
  logic [15:0] cap_a [64];
  logic [15:0] cap_d [64];

  function automatic logic [15:0] word_of(input int seed, input int k);
    return 16'((seed * 40503 + k * 4099) ^ (k << 9) ^ (seed << 3));
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_we && cap_n < 64) begin
        cap_a[cap_n] = ram_addr;
        cap_d[cap_n] = ram_wdata;
        cap_n++;
      end
      if (busy) busy_n++;
      if (cmd_error) err_n++;
    end
  end

  task automatic send_bits(input logic [15:0] v, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      ser_din = v[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
    end
  endtask

  task automatic send_frame(input logic [7:0] dev, input logic [7:0] cmd, input logic [15:0] base,
                            input int nw, input int seed, input int extra);
    @(negedge clk);
    ser_csn = 1'b0;
    repeat (3) @(negedge clk);
    send_bits({dev, cmd}, 16);
    send_bits(base, 16);
    for (int k = 0; k < nw; k++) send_bits(word_of(seed, k), 16);
    if (extra > 0) send_bits(16'h5555, extra);
    repeat (3) @(negedge clk);
    ser_csn = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // pulse the strobe and check the commit that follows
  task automatic strobe_and_check(input int exp_n, input logic [15:0] base, input int seed, input string tag);
    cap_n  = 0;
    busy_n = 0;
    @(negedge clk);
    fs_strobe = 1'b1;
    @(negedge clk);
    fs_strobe = 1'b0;
    chk(ram_we == (exp_n > 0), {tag, " R3 write starts after strobe"}, int'(ram_we), int'(exp_n > 0));
    repeat (40) @(negedge clk);
    chk(cap_n == exp_n, {tag, " write count"}, cap_n, exp_n);
    chk(busy_n == exp_n, {tag, " R3 busy length"}, busy_n, exp_n);
    for (int k = 0; k < exp_n && k < cap_n; k++) begin
      chk(cap_a[k] == 16'(base + 16'(k)), {tag, " R3 address"}, int'(cap_a[k]), int'(16'(base + 16'(k))));
      chk(cap_d[k] == word_of(seed, k), {tag, " R3 data"}, int'(cap_d[k]), int'(word_of(seed, k)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !ram_we && !cmd_error, "R9 reset outputs", int'({busy, ram_we, cmd_error}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    strobe_and_check(0, 16'h0, 0, "R9 nothing pending after reset");

    // R1 R3 R4: sweep of word counts, one wrapping base
    for (int n = 1; n <= 33; n++) begin
      logic [15:0] b;
      int exp_n;
      b = (n % 4 == 0) ? 16'hFFF0 : 16'(n * 16'h0123);
      exp_n = (n > 32) ? 32 : n;
      cap_n = 0;
      send_frame(DEV, OP, b, n, n, 0);
      repeat (20) @(negedge clk);
      chk(cap_n == 0, "R2 no write before strobe", cap_n, 0);
      strobe_and_check(exp_n, b, n, (n > 32) ? "R4 overflow" : "R1 sweep");
      strobe_and_check(0, 16'h0, 0, "R10 second strobe");
    end

    // R5: wrong device address
    send_frame(8'h5B, OP, 16'h0040, 4, 50, 0);
    strobe_and_check(0, 16'h0, 0, "R5 foreign device");

    // R6: wrong command
    send_frame(DEV, 8'hA6, 16'h0040, 4, 51, 0);
    strobe_and_check(0, 16'h0, 0, "R6 other opcode");

    // R7: partial trailing word dropped, and frame with no whole word
    send_frame(DEV, OP, 16'h0300, 2, 52, 7);
    strobe_and_check(2, 16'h0300, 52, "R7 partial tail");
    send_frame(DEV, OP, 16'h0300, 0, 53, 12);
    strobe_and_check(0, 16'h0, 0, "R7 no whole word");

    // R8: addressed frame while pending
    err_n = 0;
    send_frame(DEV, OP, 16'h0100, 3, 60, 0);
    chk(err_n == 0, "R8 no error on accepted frame", err_n, 0);
    send_frame(DEV, OP, 16'h0200, 2, 61, 0);
    chk(err_n == 1, "R8 error on locked frame", err_n, 1);
    send_frame(8'h11, OP, 16'h0200, 2, 62, 0);
    chk(err_n == 1, "R5 foreign frame raises no error", err_n, 1);
    strobe_and_check(3, 16'h0100, 60, "R8 pending set intact");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule